// File: doc/BRIEF.md
# Latched Serial-to-Parallel Shift Register

This block converts a serial bit stream into a parallel word. It has two capture points. A chain of shift stages takes one new bit at the low end on every rising edge of a shift strobe. A separate holding register copies the whole chain at once on every rising edge of a store strobe. The parallel outputs present the holding register, not the live chain, so a new word can be shifted in behind a word that is stable and visible. The top stage of the chain is also brought out as a cascade bit, so several blocks can be chained into a longer register.

Both strobes, the serial data and the active-low chain clear are treated as slow pins. Each one is sampled into a single system-clock domain through a synchronizer. Each strobe rising edge becomes a pulse that lasts exactly one system cycle. The chain clear empties only the shift stages; the holding register keeps its word. The three-state parallel outputs are represented by a data vector plus a per-bit drive-enable vector, which an integrator can map onto real tri-state pads.

Top module: `latched_shifter`

## Requirements
- R1: After system reset (`rst_n` low), the shift stages and the holding register read as zero. This means `par_q` = 0 and `cascade_out` = 0.
- R2: On each shift-strobe rising edge, `ser_in` enters stage 0 and every other stage moves up by one place. After eight shifts of bits b7 first through b0 last, followed by a store, `par_q[i]` = b[i].
- R3: On a store-strobe rising edge, the holding register copies all stages at once. Later shifts with no store edge leave `par_q` unchanged.
- R4: When both strobes rise together, the holding register captures the stage contents from before that shift. It therefore stays one shift behind the chain.
- R5: While `clr_n` is low, the shift stages are forced to zero (`cascade_out` = 0), and the holding register, and so `par_q`, is unchanged.
- R6: A store edge while `clr_n` is low loads all zeros into the holding register.
- R7: While `oe_n` is high, `par_en` is all zeros (every output bit undriven). The holding register keeps its word. When `oe_n` returns low, `par_en` is all ones and `par_q` shows the same word.
- R8: `cascade_out` always equals the top stage. On each shift edge it takes the previous value of the stage below it, whatever the level of `oe_n`.
- R9: A strobe held high acts once only. One rising edge causes exactly one shift or one store, however long the strobe stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ser_in | input | 1 | Serial data bit, sampled on shift-strobe edges |
| sh_clk | input | 1 | Shift strobe; a rising edge advances the chain |
| st_clk | input | 1 | Store strobe; a rising edge copies the chain into the holding register |
| clr_n | input | 1 | Active-low clear of the shift stages only |
| oe_n | input | 1 | Active-low output drive enable |
| par_q | output | WIDTH | Holding register contents |
| par_en | output | WIDTH | Per-bit drive enable for `par_q` (1 = driven, 0 = high impedance) |
| cascade_out | output | 1 | Top shift stage, for chaining blocks |

## Verification
A wrong stage value reaches `cascade_out` within a few shifts: the fault climbs the chain one place per shift edge. It reaches `par_q` at the next store edge, which lands a synchronizer delay (about three system cycles) after the strobe pin rises. A holding register that drifts without a store edge, or that clears when the chain clears, shows on `par_q` at once, because the bench reads `par_q` between strobes. A strobe that is detected twice, or a shared edge that captures post-shift data, shows up as a word offset by one bit against the bench's own model of the chain.

// File: rtl/lsh_pkg.sv
package lsh_pkg;
  localparam int unsigned DEF_WIDTH = 8;
  localparam int unsigned DEF_SYNC  = 2;
endpackage

// File: rtl/lsh_sync.sv
module lsh_sync #(
  parameter int unsigned DEPTH   = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [DEPTH-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = {sr_q[DEPTH-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= {DEPTH{RST_VAL}};
    else        sr_q <= sr_d;
  end

  assign dout = sr_q[DEPTH-1];
endmodule

// File: rtl/lsh_rise.sv
module lsh_rise #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic pulse
);
  logic lvl, lvl_q;

  lsh_sync #(.DEPTH(DEPTH), .RST_VAL(1'b0)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin), .dout(lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign pulse = lvl & ~lvl_q;
endmodule

// File: rtl/lsh_shift_chain.sv
module lsh_shift_chain #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         clear_n,
  input  logic         ser,
  output logic [W-1:0] stages
);
  logic [W-1:0] stg_q, stg_d, src;

  for (genvar i = 0; i < W; i++) begin : g_src
    if (i == 0) begin : g_low
      assign src[i] = ser;
    end else begin : g_up
      assign src[i] = stg_q[i-1];
    end
  end

  always_comb begin
    stg_d = stg_q;
    if (!clear_n)      stg_d = '0;
    else if (shift_en) stg_d = src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign stages = stg_q;
endmodule

// File: rtl/lsh_hold_reg.sv
module lsh_hold_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r, q_d;

  always_comb begin
    q_d = q_r;
    if (load) q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/latched_shifter.sv
module latched_shifter #(
  parameter int unsigned WIDTH = lsh_pkg::DEF_WIDTH,
  parameter int unsigned SYNC  = lsh_pkg::DEF_SYNC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  input  logic             sh_clk,
  input  logic             st_clk,
  input  logic             clr_n,
  input  logic             oe_n,
  output logic [WIDTH-1:0] par_q,
  output logic [WIDTH-1:0] par_en,
  output logic             cascade_out
);
  logic             sh_pulse, st_pulse, ser_s, clr_s;
  logic [WIDTH-1:0] stages, hold;

  lsh_rise #(.DEPTH(SYNC)) u_sh_edge (
    .clk(clk), .rst_n(rst_n), .pin(sh_clk), .pulse(sh_pulse)
  );

  lsh_rise #(.DEPTH(SYNC)) u_st_edge (
    .clk(clk), .rst_n(rst_n), .pin(st_clk), .pulse(st_pulse)
  );

  lsh_sync #(.DEPTH(SYNC), .RST_VAL(1'b0)) u_ser_sync (
    .clk(clk), .rst_n(rst_n), .din(ser_in), .dout(ser_s)
  );

  lsh_sync #(.DEPTH(SYNC), .RST_VAL(1'b1)) u_clr_sync (
    .clk(clk), .rst_n(rst_n), .din(clr_n), .dout(clr_s)
  );

  lsh_shift_chain #(.W(WIDTH)) u_chain (
    .clk(clk), .rst_n(rst_n), .shift_en(sh_pulse), .clear_n(clr_s),
    .ser(ser_s), .stages(stages)
  );

  lsh_hold_reg #(.W(WIDTH)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(st_pulse), .d(stages), .q(hold)
  );

  assign par_q       = hold;
  assign par_en      = {WIDTH{~oe_n}};
  assign cascade_out = stages[WIDTH-1];
endmodule

// File: rtl/lsh_checker.sv
module lsh_checker #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sh_pulse,
  input logic             st_pulse,
  input logic             clr_s,
  input logic             ser_s,
  input logic [WIDTH-1:0] stages,
  input logic [WIDTH-1:0] par_q,
  input logic             cascade_out
);
  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st_pulse |=> $stable(par_q));

  // R4
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_pulse |=> par_q == $past(stages));

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_s |=> stages == '0);

  // R2
  shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_pulse && clr_s) |=> stages == {$past(stages[WIDTH-2:0]), $past(ser_s)});

  // R8
  cascade_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_pulse && clr_s) |=> cascade_out == $past(stages[WIDTH-2]));

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_pulse || st_pulse) |=> !($past(sh_pulse) && sh_pulse) && !($past(st_pulse) && st_pulse));
endmodule

bind latched_shifter lsh_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sh_pulse(sh_pulse), .st_pulse(st_pulse),
  .clr_s(clr_s), .ser_s(ser_s), .stages(stages), .par_q(par_q),
  .cascade_out(cascade_out)
);

// File: tb/latched_shifter_test.sv
`timescale 1ns/1ps
module latched_shifter_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n, ser_in, sh_clk, st_clk, clr_n, oe_n;
  logic [W-1:0] par_q, par_en;
  logic cascade_out;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] model;

  always #2 clk = ~clk;

  latched_shifter uut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .sh_clk(sh_clk),
    .st_clk(st_clk), .clr_n(clr_n), .oe_n(oe_n), .par_q(par_q),
    .par_en(par_en), .cascade_out(cascade_out)
  );

  // each entry: {serial data, number of bits shifted, MSB of that count first}
  localparam logic [11:0] VEC [7] = '{
    {8'hA5, 4'd8}, {8'h3C, 4'd8}, {8'hFF, 4'd8}, {8'h00, 4'd8},
    {8'h0B, 4'd4}, {8'h01, 4'd1}, {8'h5A, 4'd3}
  };

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk);
    ser_in = b; sh_clk = 1'b1;
    settle();
    sh_clk = 1'b0;
    settle();
    if (clr_n) model = {model[W-2:0], b};
  endtask

  task automatic store();
    @(negedge clk);
    st_clk = 1'b1;
    settle();
    st_clk = 1'b0;
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] held, prev;
    rst_n = 1'b0; ser_in = 1'b0; sh_clk = 1'b0; st_clk = 1'b0;
    clr_n = 1'b1; oe_n = 1'b0; model = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 par_q", par_q, '0);
    check("R1 cascade", {7'd0, cascade_out}, '0);
    rst_n = 1'b1;
    settle();
    check("R1 par_q after release", par_q, '0);

    // R2 table walk: shift, store, compare with model
    for (int v = 0; v < 7; v++) begin
      for (int b = int'(VEC[v][3:0]) - 1; b >= 0; b--) shift_bit(VEC[v][4+b]);
      store();
      check("R2 par_q", par_q, model);
      check("R8 cascade", {7'd0, cascade_out}, {7'd0, model[W-1]});
    end

    // R3 shifts without store leave par_q alone
    held = par_q;
    shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b1);
    check("R3 par_q held", par_q, held);
    check("R8 cascade live", {7'd0, cascade_out}, {7'd0, model[W-1]});

    // R4 shared edge captures pre-shift contents
    prev = model;
    @(negedge clk);
    ser_in = 1'b1; sh_clk = 1'b1; st_clk = 1'b1;
    settle();
    sh_clk = 1'b0; st_clk = 1'b0;
    settle();
    model = {model[W-2:0], 1'b1};
    check("R4 par_q one behind", par_q, prev);
    store();
    check("R4 par_q after store", par_q, model);

    // R9 strobe held high shifts once
    @(negedge clk);
    ser_in = 1'b0; sh_clk = 1'b1;
    repeat (20) @(negedge clk);
    sh_clk = 1'b0;
    settle();
    model = {model[W-2:0], 1'b0};
    store();
    check("R9 single shift", par_q, model);

    // R7 output enable
    held = par_q;
    @(negedge clk); oe_n = 1'b1;
    @(negedge clk);
    check("R7 par_en off", par_en, '0);
    shift_bit(1'b1);
    check("R8 cascade with oe high", {7'd0, cascade_out}, {7'd0, model[W-1]});
    @(negedge clk); oe_n = 1'b0;
    @(negedge clk);
    check("R7 par_en on", par_en, '1);
    check("R7 par_q kept", par_q, held);

    // R5 clear empties stages, holding kept
    @(negedge clk); clr_n = 1'b0;
    settle();
    model = '0;
    check("R5 cascade cleared", {7'd0, cascade_out}, '0);
    check("R5 par_q kept", par_q, held);

    // R6 store while clear low loads zero
    store();
    check("R6 par_q zero", par_q, '0);
    @(negedge clk); clr_n = 1'b1;
    settle();
    for (int b = 7; b >= 0; b--) shift_bit(b[0]);
    store();
    check("R2 after clear", par_q, model);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 par_q reset", par_q, '0);
    check("R1 cascade reset", {7'd0, cascade_out}, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule